// File: doc/BRIEF.md
# Self-Timed SRAM Access Sequencer

This block is a cycle-level digital model of the control path of a synchronous single-port SRAM. An access starts at a rising clock edge that sees the chip enable high. The sequencer then issues a one-cycle internal clock pulse and opens the word line window. The window does not last a fixed number of cycles. It stays open until a replica-tracking event reports that the replica bit line has fallen to its threshold, which stands for about half the supply. The delay of that event scales with the number of rows in the array.

For a read, the replica event closes the word line and fires a single-cycle sense enable. A data-valid pulse follows one cycle later. For a write, the same replica-timed window drives the word line together with a write enable, and no sense enable or data-valid is produced. The replica bit cells always store zero, so every access gets a replica event. A request that arrives while an access is still in flight is rejected: the sequencer raises a one-cycle error flag and drops the request. The replica delay comes from outside the block; in the bench a counter programmed by row count produces it.

Top module: `rdseq_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every output is low: icp, wl_en, wr_en, sa_en, dvalid and err.
- R2: If ce is high at an edge while the block is idle (wl_en and sa_en both low), icp is high in the following cycle for exactly one cycle, and wl_en rises in that same cycle.
- R3: During a read window, wl_en stays high at every edge where rep_done is low. At the first edge where rep_done is high, wl_en falls and sa_en rises in the same cycle.
- R4: sa_en is high for exactly one cycle. dvalid is high in the cycle after it, also for exactly one cycle.
- R5: The wr level sampled at the accepting edge (1 = write) selects a write. For a write, wr_en is high in exactly the cycles where wl_en is high and falls with it at the rep_done edge. sa_en and dvalid stay low. Changes on wr after the accepting edge have no effect.
- R6: If ce is high at an edge while wl_en or sa_en is high, err is high for the next cycle only. The request is dropped: no icp follows, and the window or sense cycle in progress continues unchanged.
- R7: rep_done has no effect when wl_en is low. Outputs stay low while the block is idle, and a sense cycle still ends after one cycle.
- R8: A new request is accepted in the cycle where dvalid is high, and in the cycle right after a write window closes, so accesses can run back to back.
- R9: wl_en and sa_en are never high together, and wr_en is never high without wl_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every access starts on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ce | input | 1 | Chip enable: requests an access |
| wr | input | 1 | Access type sampled with ce: 1 = write, 0 = read |
| rep_done | input | 1 | Replica bit line has reached its threshold |
| icp | output | 1 | One-cycle internal clock pulse at access start |
| wl_en | output | 1 | Word line enable for the replica-timed window |
| wr_en | output | 1 | Write drivers enabled, during a write window only |
| sa_en | output | 1 | One-cycle sense amplifier enable, reads only |
| dvalid | output | 1 | Read data valid, one cycle after sense |
| err | output | 1 | One-cycle flag for a request rejected while busy |

## Verification
The bench targets the shortest window, where rep_done arrives at the first edge after launch. A design that needs a minimum window width would keep wl_en high one cycle too long there. It sends requests during every window cycle, including the closing edge and the sense cycle. A design that accepts them would emit a second icp or restart the window. It also issues a new request in the dvalid cycle and right after a write, so a design that keeps a dead cycle there would drop the access without flagging an error. Random stray rep_done pulses while idle, and wr toggling inside a window, show up as a spurious sense pulse or a flipping write enable if the design reacts to them.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RWIN  = 2'd1,
        ST_WWIN  = 2'd2,
        ST_SENSE = 2'd3
    } seq_st_e;

    typedef struct packed {
        seq_st_e st;
        logic    icp;
    } fsm_reg_s;

    typedef struct packed {
        logic err;
    } gate_reg_s;

    typedef struct packed {
        logic dv;
    } drv_reg_s;

endpackage

// File: rtl/rdseq_gate.sv
module rdseq_gate
    import rdseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic busy,
    output logic accept,
    output logic err
);

    gate_reg_s r_d, r_q;

    always_comb begin
        accept  = ce & ~busy;
        r_d     = r_q;
        r_d.err = ce & busy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign err = r_q.err;

endmodule

// File: rtl/rdseq_fsm.sv
module rdseq_fsm
    import rdseq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    accept,
    input  logic    wr,
    input  logic    rep_done,
    output seq_st_e st,
    output logic    icp
);

    fsm_reg_s r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.icp = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    r_d.st  = wr ? ST_WWIN : ST_RWIN;
                    r_d.icp = 1'b1;
                end
            end
            ST_RWIN: begin
                if (rep_done) r_d.st = ST_SENSE;
            end
            ST_WWIN: begin
                if (rep_done) r_d.st = ST_IDLE;
            end
            ST_SENSE: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, icp: 1'b0};
        else        r_q <= r_d;
    end

    assign st  = r_q.st;
    assign icp = r_q.icp;

endmodule

// File: rtl/rdseq_drv.sv
module rdseq_drv
    import rdseq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  seq_st_e st,
    output logic    wl_en,
    output logic    wr_en,
    output logic    sa_en,
    output logic    dvalid,
    output logic    busy
);

    drv_reg_s r_d, r_q;

    always_comb begin
        wl_en  = (st == ST_RWIN) || (st == ST_WWIN);
        wr_en  = (st == ST_WWIN);
        sa_en  = (st == ST_SENSE);
        busy   = (st != ST_IDLE);
        r_d    = r_q;
        r_d.dv = sa_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dvalid = r_q.dv;

endmodule

// File: rtl/rdseq_top.sv
module rdseq_top
    import rdseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic wr,
    input  logic rep_done,
    output logic icp,
    output logic wl_en,
    output logic wr_en,
    output logic sa_en,
    output logic dvalid,
    output logic err
);

    logic    accept;
    logic    busy;
    seq_st_e st;

    rdseq_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce     (ce),
        .busy   (busy),
        .accept (accept),
        .err    (err)
    );

    rdseq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .wr       (wr),
        .rep_done (rep_done),
        .st       (st),
        .icp      (icp)
    );

    rdseq_drv u_drv (
        .clk    (clk),
        .rst_n  (rst_n),
        .st     (st),
        .wl_en  (wl_en),
        .wr_en  (wr_en),
        .sa_en  (sa_en),
        .dvalid (dvalid),
        .busy   (busy)
    );

endmodule

// File: rtl/rdseq_chk.sv
module rdseq_chk (
    input logic clk,
    input logic rst_n,
    input logic ce,
    input logic wr,
    input logic rep_done,
    input logic icp,
    input logic wl_en,
    input logic wr_en,
    input logic sa_en,
    input logic dvalid,
    input logic err
);

    // R1: outputs are low in the cycle after a reset edge
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!icp && !wl_en && !wr_en && !sa_en && !dvalid && !err));

    // R2
    a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !wl_en && !sa_en) |=> (icp && wl_en));

    a_r2_icp_single: assert property (@(posedge clk) disable iff (!rst_n)
        icp |=> !icp);

    // R3
    a_r3_hold_window: assert property (@(posedge clk) disable iff (!rst_n)
        (wl_en && !rep_done) |=> wl_en);

    a_r3_close_read: assert property (@(posedge clk) disable iff (!rst_n)
        (wl_en && !wr_en && rep_done) |=> (!wl_en && sa_en));

    // R4
    a_r4_sense_then_valid: assert property (@(posedge clk) disable iff (!rst_n)
        sa_en |=> (!sa_en && dvalid));

    a_r4_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        dvalid |=> !dvalid);

    // R5
    a_r5_write_close: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rep_done) |=> (!wl_en && !wr_en && !sa_en));

    a_r5_write_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rep_done) |=> wr_en);

    // R6
    a_r6_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && (wl_en || sa_en)) |=> (err && !icp));

    a_r6_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(ce && (wl_en || sa_en))) |=> !err);

    // R7
    a_r7_stray_replica: assert property (@(posedge clk) disable iff (!rst_n)
        (!wl_en && rep_done) |=> !sa_en);

    // R8
    a_r8_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (dvalid && ce) |=> icp);

    // R9
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wl_en && sa_en) && (!wr_en || wl_en));

endmodule

bind rdseq_top rdseq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce       (ce),
    .wr       (wr),
    .rep_done (rep_done),
    .icp      (icp),
    .wl_en    (wl_en),
    .wr_en    (wr_en),
    .sa_en    (sa_en),
    .dvalid   (dvalid),
    .err      (err)
);

// File: tb/rdseq_top_bench.sv
`timescale 1ns/1ps
module rdseq_top_bench;

    localparam int ROWS_PER_CYC = 32;
    localparam int WATCHDOG_CYC = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce = 1'b0;
    logic wr = 1'b0;
    logic rep_done = 1'b0;
    logic icp, wl_en, wr_en, sa_en, dvalid, err;

    int n_chk = 0;
    int n_bad = 0;
    bit pend_err = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rdseq_top u_rdseq_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce       (ce),
        .wr       (wr),
        .rep_done (rep_done),
        .icp      (icp),
        .wl_en    (wl_en),
        .wr_en    (wr_en),
        .sa_en    (sa_en),
        .dvalid   (dvalid),
        .err      (err)
    );

    // replica delay in cycles, programmed by row count
    function automatic int rep_cycles(input int rows);
        int c;
        c = (rows + ROWS_PER_CYC - 1) / ROWS_PER_CYC;
        return (c < 1) ? 1 : c;
    endfunction

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_all(input string req, input logic e_icp, input logic e_wl,
                           input logic e_wr, input logic e_sa, input logic e_dv,
                           input logic e_err);
        chk(req, "icp",    icp,    e_icp);
        chk(req, "wl_en",  wl_en,  e_wl);
        chk(req, "wr_en",  wr_en,  e_wr);
        chk(req, "sa_en",  sa_en,  e_sa);
        chk(req, "dvalid", dvalid, e_dv);
        chk(req, "err",    err,    e_err);
    endtask

    // One access of window length d; intr = cycle of a rejected request
    // (0 none, 1..d inside window, d+1 the sense cycle of a read).
    // Starts and ends at a negedge.
    task automatic run_access(input bit w, input int d, input int intr);
        ce = 1'b1; wr = w; rep_done = 1'b0; pend_err = 1'b0;
        for (int i = 1; i <= d; i++) begin
            @(negedge clk);
            // R2 launch / R3 hold / R5 write enable / R6 reject
            chk(w ? "R5" : "R3", "window", wl_en, 1'b1);
            chk("R2", "icp", icp, (i == 1));
            chk("R5", "wr_en", wr_en, w);
            chk("R9", "sa_en in window", sa_en, 1'b0);
            chk("R6", "err", err, pend_err);
            ce = 1'b0; pend_err = 1'b0;
            wr = 1'($urandom_range(0, 1));   // R5: ignored after launch
            if (intr == i) begin ce = 1'b1; pend_err = 1'b1; end
            rep_done = (i == d);
        end
        @(negedge clk);
        chk_all(w ? "R5" : "R3", 1'b0, 1'b0, 1'b0, !w, 1'b0, pend_err);
        ce = 1'b0; rep_done = 1'b0; pend_err = 1'b0;
        if (!w) begin
            if (intr == d + 1) begin ce = 1'b1; pend_err = 1'b1; end
            @(negedge clk);
            chk_all("R4", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, pend_err);
            ce = 1'b0; pend_err = 1'b0;
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int k = 0; k < n; k++) begin
            ce = 1'b0;
            rep_done = 1'($urandom_range(0, 1));   // R7: stray replica events
            @(negedge clk);
            chk_all("R7", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        end
        rep_done = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: during and right after reset
        repeat (3) @(negedge clk);
        chk_all("R1", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

        // directed corners
        run_access(1'b0, 1, 0);                 // shortest read window
        run_access(1'b1, 1, 0);                 // R8: right after read dvalid
        run_access(1'b0, rep_cycles(1024), 0);  // tallest array
        idle_cycles(4);
        run_access(1'b0, 3, 1);                 // R6 reject at launch cycle
        run_access(1'b0, 3, 3);                 // R6 reject at closing edge
        run_access(1'b0, 2, 3);                 // R6 reject in sense cycle
        run_access(1'b1, 4, 2);                 // R6 reject in write window
        run_access(1'b1, 2, 0);
        run_access(1'b0, rep_cycles(16), 0);    // R8: right after write
        idle_cycles(3);

        // constrained random mix
        for (int t = 0; t < 150; t++) begin
            bit w;
            int d;
            int intr;
            w = 1'($urandom_range(0, 1));
            d = rep_cycles(16 * int'($urandom_range(1, 64)));
            intr = ($urandom_range(0, 2) == 0) ? int'($urandom_range(1, d + 1)) : 0;
            run_access(w, d, intr);
            if ($urandom_range(0, 3) == 0) idle_cycles(int'($urandom_range(1, 3)));
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule